// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets bus write cycles on a 16-bit parallel NOR flash that keeps software data protection permanently on. It turns each write strobe into a single write event. It compares the low data byte and the low 16 address bits of each write against multi-write unlock sequences. When a sequence completes, it raises a one-cycle action pulse for program, sector erase, block erase or chip erase. The pulse carries the latched target address and data.

The block also holds the current read mode: array, product identification or CFI query. In the two non-array modes it supplies the read word for the current address, so the read path can select it in place of array data. A separate status block reports busy while an internal operation runs. While busy is high, the decoder refuses to drop back to array mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is taken only while ce_ni is low, we_ni is low and oe_ni is high. A strobe held in that state for several cycles counts as exactly one write, taken on its first cycle.
- R2: The writes AAh at 5555h, 55h at 2AAAh and A0h at 5555h, followed by any fourth write, raise prog_o for exactly one cycle. The pulse comes in the cycle after the fourth write is taken, with act_addr_o and act_data_o equal to that write's full address and data.
- R3: The writes AAh/5555h, 55h/2AAAh, 80h/5555h, AAh/5555h and 55h/2AAAh, followed by a sixth write, raise a one-cycle erase pulse. A sixth write of 30h at any address gives erase_sector_o. A sixth write of 50h at any address gives erase_block_o. A sixth write of 10h at 5555h gives erase_chip_o. In each case act_addr_o is the sixth write's address.
- R4: Any write that is not the expected next step restarts the sequence, issues no action, and sets the read mode to array. This includes a chip erase write at the wrong address and a stray write while in ID or CFI mode.
- R5: Data bits 15 to 8 are ignored in every command compare. Only address bits 15 to 0 are compared against 5555h and 2AAAh.
- R6: The third write 90h at 5555h enters product ID mode, and rd_mode_o becomes 1. In that mode a read of address 0 returns 00BFh, a read of address 1 returns 2781h, and any other address returns 0000h.
- R7: The third write 98h at 5555h enters CFI query mode, and rd_mode_o becomes 2. The stub returns 0051h, 0052h and 0059h at addresses 10h, 11h and 12h, and 0000h at any other address.
- R8: The third write F0h at 5555h returns the read mode to array. While busy_i is high, both this exit and a mismatch abort leave the mode unchanged, though the sequence still restarts.
- R9: At most one action pulse is high in any cycle. In array mode rd_data_o is 0000h.
- R10: After reset the read mode is array and no action pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write data |
| busy_i | input | 1 | Internal program/erase in progress |
| rd_mode_o | output | 2 | Read mode: 0 array, 1 product ID, 2 CFI |
| rd_data_o | output | DATA_W | ID or CFI word for addr_i, zero in array mode |
| prog_o | output | 1 | Program action pulse |
| erase_sector_o | output | 1 | Sector erase action pulse |
| erase_block_o | output | 1 | Block erase action pulse |
| erase_chip_o | output | 1 | Chip erase action pulse |
| act_addr_o | output | ADDR_W | Address latched with the last action |
| act_data_o | output | DATA_W | Data latched with the last action |

## Verification
Two cases are the hardest to reach from the pins. The first is a mode change being held off by busy_i: the bench first enters ID mode through a full three-write sequence, raises busy_i between writes, and then issues both a proper exit and a stray write, which must leave the mode alone. The second is the sixth write of a chip erase arriving at the wrong address, which needs five correct writes before the failing one. Extra stimulus covers strobes held low for several cycles and writes blocked by OE or CE, both placed where a counted write would visibly abort ID mode.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;
  typedef enum logic [1:0] {MODE_ARRAY = 2'd0, MODE_ID = 2'd1, MODE_CFI = 2'd2} rd_mode_e;
  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_UNL1, SEQ_UNL2, SEQ_PROG, SEQ_ERS1, SEQ_ERS2, SEQ_ERS3
  } seq_e;

  localparam int ACT_N    = 4;
  localparam int ACT_PROG = 0;
  localparam int ACT_SECT = 1;
  localparam int ACT_BLK  = 2;
  localparam int ACT_CHIP = 3;

  localparam int CMP_W = 16;
  localparam logic [CMP_W-1:0] ADR_KEY_A = 16'h5555;
  localparam logic [CMP_W-1:0] ADR_KEY_B = 16'h2AAA;

  localparam logic [7:0] CMD_KEY_A = 8'hAA;
  localparam logic [7:0] CMD_KEY_B = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_CFI   = 8'h98;
  localparam logic [7:0] CMD_EXIT  = 8'hF0;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_BLK   = 8'h50;
endpackage

// File: rtl/fcd_wr_strobe.sv
`timescale 1ns/1ps
module fcd_wr_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic take_o
);
  logic wr_act, wr_q;

  assign wr_act = ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_act;
  end

  // one write per strobe low period
  assign take_o = wr_act & ~wr_q;

  a_r1_single_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
endmodule

// File: rtl/fcd_seq_fsm.sv
`timescale 1ns/1ps
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              busy_i,
  output rd_mode_e          mode_o,
  output logic [ACT_N-1:0]  act_o,
  output logic [ADDR_W-1:0] act_addr_o,
  output logic [DATA_W-1:0] act_data_o
);
  seq_e              seq_q, seq_d;
  rd_mode_e          mode_q, mode_d;
  logic [ACT_N-1:0]  act_q, act_d;
  logic [ADDR_W-1:0] act_addr_q;
  logic [DATA_W-1:0] act_data_q;
  logic [7:0]        cmd;
  logic              at_a, at_b, abort;

  assign cmd  = data_i[7:0];
  assign at_a = addr_i[CMP_W-1:0] == ADR_KEY_A;
  assign at_b = addr_i[CMP_W-1:0] == ADR_KEY_B;

  always_comb begin
    seq_d  = seq_q;
    mode_d = mode_q;
    act_d  = '0;
    abort  = 1'b0;
    if (take_i) begin
      unique case (seq_q)
        SEQ_IDLE: if (at_a && cmd == CMD_KEY_A) seq_d = SEQ_UNL1; else abort = 1'b1;
        SEQ_UNL1: if (at_b && cmd == CMD_KEY_B) seq_d = SEQ_UNL2; else abort = 1'b1;
        SEQ_UNL2: begin
          if (!at_a) abort = 1'b1;
          else begin
            unique case (cmd)
              CMD_PROG:  seq_d = SEQ_PROG;
              CMD_ERASE: seq_d = SEQ_ERS1;
              CMD_ID:    begin seq_d = SEQ_IDLE; mode_d = MODE_ID;  end
              CMD_CFI:   begin seq_d = SEQ_IDLE; mode_d = MODE_CFI; end
              CMD_EXIT:  begin
                seq_d = SEQ_IDLE;
                if (!busy_i) mode_d = MODE_ARRAY;
              end
              default:   abort = 1'b1;
            endcase
          end
        end
        SEQ_PROG: begin
          act_d[ACT_PROG] = 1'b1;
          seq_d = SEQ_IDLE;
        end
        SEQ_ERS1: if (at_a && cmd == CMD_KEY_A) seq_d = SEQ_ERS2; else abort = 1'b1;
        SEQ_ERS2: if (at_b && cmd == CMD_KEY_B) seq_d = SEQ_ERS3; else abort = 1'b1;
        SEQ_ERS3: begin
          seq_d = SEQ_IDLE;
          if (cmd == CMD_SECT)             act_d[ACT_SECT] = 1'b1;
          else if (cmd == CMD_BLK)         act_d[ACT_BLK]  = 1'b1;
          else if (cmd == CMD_CHIP && at_a) act_d[ACT_CHIP] = 1'b1;
          else abort = 1'b1;
        end
        default: abort = 1'b1;
      endcase
    end
    if (abort) begin
      seq_d = SEQ_IDLE;
      if (!busy_i) mode_d = MODE_ARRAY;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q      <= SEQ_IDLE;
      mode_q     <= MODE_ARRAY;
      act_q      <= '0;
      act_addr_q <= '0;
      act_data_q <= '0;
    end else begin
      seq_q  <= seq_d;
      mode_q <= mode_d;
      act_q  <= act_d;
      if (|act_d) begin
        act_addr_q <= addr_i;
        act_data_q <= data_i;
      end
    end
  end

  assign mode_o     = mode_q;
  assign act_o      = act_q;
  assign act_addr_o = act_addr_q;
  assign act_data_o = act_data_q;

  a_r9_act_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_q));
  a_r9_act_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|act_q) |=> !(|act_q));
  a_r2_act_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|act_q) |-> $past(take_i));
  a_r8_busy_holds_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && mode_q != MODE_ARRAY) |=> mode_q != MODE_ARRAY);
  a_r4_mode_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(mode_q));
endmodule

// File: rtl/fcd_read_rom.sv
`timescale 1ns/1ps
module fcd_read_rom
  import fcd_pkg::*;
#(
  parameter int              ADDR_W   = 19,
  parameter int              DATA_W   = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00BF,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h2781,
  parameter int              CFI_BASE = 16
) (
  input  rd_mode_e          mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int          CFI_N   = 3;
  localparam logic [23:0] CFI_TAG = 24'h515259;

  logic [CFI_N-1:0]  cfi_hit;
  logic [DATA_W-1:0] cfi_word [CFI_N];

  for (genvar g = 0; g < CFI_N; g++) begin : g_cfi
    assign cfi_hit[g]  = addr_i == ADDR_W'(CFI_BASE + g);
    assign cfi_word[g] = DATA_W'(CFI_TAG[8*(CFI_N-1-g) +: 8]);
  end

  always_comb begin
    rd_data_o = '0;
    unique case (mode_i)
      MODE_ID: begin
        if (addr_i == '0)                rd_data_o = MFR_CODE;
        else if (addr_i == ADDR_W'(1))   rd_data_o = DEV_CODE;
      end
      MODE_CFI: begin
        for (int i = 0; i < CFI_N; i++)
          if (cfi_hit[i]) rd_data_o = cfi_word[i];
      end
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              busy_i,
  output logic [1:0]        rd_mode_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              prog_o,
  output logic              erase_sector_o,
  output logic              erase_block_o,
  output logic              erase_chip_o,
  output logic [ADDR_W-1:0] act_addr_o,
  output logic [DATA_W-1:0] act_data_o
);
  logic             take;
  rd_mode_e         mode;
  logic [ACT_N-1:0] act;

  fcd_wr_strobe u_strobe (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .ce_ni (ce_ni), .we_ni (we_ni), .oe_ni (oe_ni),
    .take_o(take)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .busy_i    (busy_i),
    .mode_o    (mode),
    .act_o     (act),
    .act_addr_o(act_addr_o),
    .act_data_o(act_data_o)
  );

  fcd_read_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .mode_i   (mode),
    .addr_i   (addr_i),
    .rd_data_o(rd_data_o)
  );

  assign rd_mode_o      = mode;
  assign prog_o         = act[ACT_PROG];
  assign erase_sector_o = act[ACT_SECT];
  assign erase_block_o  = act[ACT_BLK];
  assign erase_chip_o   = act[ACT_CHIP];

  a_r6_mfr_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mode_o == 2'd1 && addr_i == '0) |-> rd_data_o == DATA_W'(16'h00BF));
  a_r6_dev_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mode_o == 2'd1 && addr_i == ADDR_W'(1)) |-> rd_data_o == DATA_W'(16'h2781));
  a_r9_array_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mode_o == 2'd0) |-> rd_data_o == '0);
  a_r1_no_act_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_ni == 1'b0 && we_ni == 1'b0 && oe_ni == 1'b1) |=> !(prog_o || erase_sector_o || erase_block_o || erase_chip_o));
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] data = '0;

  logic [1:0]        rd_mode;
  logic [DATA_W-1:0] rd_data, act_data;
  logic [ADDR_W-1:0] act_addr;
  logic              prog, e_sect, e_blk, e_chip;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(data), .busy_i(busy),
    .rd_mode_o(rd_mode), .rd_data_o(rd_data),
    .prog_o(prog), .erase_sector_o(e_sect), .erase_block_o(e_blk), .erase_chip_o(e_chip),
    .act_addr_o(act_addr), .act_data_o(act_data)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R10";
  bit    done = 1'b0;

  // reference model
  int qa[$];
  int qd[$];
  int m_mode = 0;
  bit m_prev = 1'b0;
  logic [3:0]        e_act = '0;   // {chip, blk, sect, prog}
  logic [ADDR_W-1:0] e_addr = '0;
  logic [DATA_W-1:0] e_data = '0;

  function automatic int judge();
    int n = qa.size();
    if (!(qa[0] == 'h5555 && qd[0] == 'hAA)) return -1;
    if (n == 1) return 0;
    if (!(qa[1] == 'h2AAA && qd[1] == 'h55)) return -1;
    if (n == 2) return 0;
    if (qa[2] != 'h5555) return -1;
    if (qd[2] == 'h90) return 6;
    if (qd[2] == 'h98) return 7;
    if (qd[2] == 'hF0) return 8;
    if (qd[2] == 'hA0) return (n == 3) ? 0 : 2;
    if (qd[2] != 'h80) return -1;
    if (n == 3) return 0;
    if (!(qa[3] == 'h5555 && qd[3] == 'hAA)) return -1;
    if (n == 4) return 0;
    if (!(qa[4] == 'h2AAA && qd[4] == 'h55)) return -1;
    if (n == 5) return 0;
    if (qd[5] == 'h30) return 3;
    if (qd[5] == 'h50) return 4;
    if (qd[5] == 'h10 && qa[5] == 'h5555) return 5;
    return -1;
  endfunction

  task automatic model_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int r;
    qa.push_back(int'(a[15:0]));
    qd.push_back(int'(d[7:0]));
    r = judge();
    if (r != 0) begin qa.delete(); qd.delete(); end
    case (r)
      -1, 8: if (!busy) m_mode = 0;
      6: m_mode = 1;
      7: m_mode = 2;
      2, 3, 4, 5: begin
        e_act[r-2] = 1'b1;
        e_addr = a;
        e_data = d;
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    bit wr;
    if (!rst_n) begin
      m_mode = 0; m_prev = 1'b0; e_act = '0; qa.delete(); qd.delete();
    end else begin
      e_act = '0;
      wr = !ce_n && !we_n && oe_n;
      if (wr && !m_prev) model_write(addr, data);
      m_prev = wr;
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_rd();
    if (m_mode == 1) begin
      if (addr == 0) return 16'h00BF;
      if (addr == 1) return 16'h2781;
    end else if (m_mode == 2) begin
      if (addr == 'h10) return 16'h0051;
      if (addr == 'h11) return 16'h0052;
      if (addr == 'h12) return 16'h0059;
    end
    return '0;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] act_v;
      act_v = {e_chip, e_blk, e_sect, prog};
      check(act_v === e_act, "action pulses", act_v, e_act);
      check(rd_mode === 2'(m_mode), "read mode", rd_mode, m_mode);
      check(rd_data === exp_rd(), "read data", rd_data, exp_rd());
      if (|e_act) begin
        check(act_addr === e_addr, "action address", act_addr, e_addr);
        check(act_data === e_data, "action data", act_data, e_data);
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                    input int hold = 1, input logic oe = 1'b1, input logic ce = 1'b0);
    @(negedge clk); #1;
    addr = a; data = d; ce_n = ce; we_n = 1'b0; oe_n = oe;
    repeat (hold) @(negedge clk);
    #1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    @(negedge clk); #1;
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); #1;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock();
    wr('h5555, 16'h00AA);
    wr('h2AAA, 16'h0055);
  endtask

  task automatic set_busy(input logic b);
    @(negedge clk); #1; busy = b;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur_req = "R10";
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    cur_req = "R2";
    unlock(); wr('h5555, 16'h00A0); wr('h12345, 16'hBEEF);

    cur_req = "R5";
    wr('h45555, 16'h12AA); wr('h72AAA, 16'hFF55); wr('h05555, 16'h77A0); wr('h00010, 16'h1234);

    cur_req = "R3";
    unlock(); wr('h5555, 16'h0080); unlock(); wr('h30000, 16'h0030);
    unlock(); wr('h5555, 16'h0080); unlock(); wr('h4F000, 16'hAB50);
    unlock(); wr('h5555, 16'h0080); unlock(); wr('h5555, 16'h0010);

    cur_req = "R4";
    unlock(); wr('h5555, 16'h0080); unlock(); wr('h1234, 16'h0010);
    wr('h5555, 16'h00AA); wr('h2AAB, 16'h0055); wr('h5555, 16'h00A0); wr('h100, 16'h0001);
    unlock(); wr('h5555, 16'h00B0); wr('h200, 16'h0002);

    cur_req = "R6";
    unlock(); wr('h5555, 16'h0090);
    rd(0); rd(1); rd(2); rd('h40000);

    cur_req = "R4";
    wr('h100, 16'h0000); rd(0);

    cur_req = "R7";
    unlock(); wr('h5555, 16'h0098);
    rd('h10); rd('h11); rd('h12); rd('h13); rd(0);
    unlock(); wr('h5555, 16'h00F0); rd('h10);

    cur_req = "R8";
    unlock(); wr('h5555, 16'h0090);
    set_busy(1'b1);
    unlock(); wr('h5555, 16'h00F0); rd(1);
    wr('h77, 16'h0077); rd(0);
    set_busy(1'b0);
    unlock(); wr('h5555, 16'h00F0); rd(0);

    cur_req = "R1";
    unlock(); wr('h5555, 16'h0090);
    wr('h300, 16'h0000, 1, 1'b0, 1'b0); rd(0);
    wr('h300, 16'h0000, 1, 1'b1, 1'b1); rd(1);
    unlock(); wr('h5555, 16'h00F0);
    unlock(); wr('h5555, 16'h00A0, 3); wr('h00ABC, 16'h5A5A, 3);

    cur_req = "R9";
    unlock(); wr('h5555, 16'h0090);
    unlock(); wr('h5555, 16'h0080); unlock(); wr('h21000, 16'h0030); rd(0);
    unlock(); wr('h5555, 16'h00F0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule